// File: doc/BRIEF.md
# Multi-Output Digital PWM Controller

This block drives six gate-control outputs of a switching power converter from one shared period counter. Each output rises at its own programmable count and stays high for a number of counts given by the duty command. The duty command comes either from the loop filter or from a processor register, chosen by a select input. A new command is captured only when a switching cycle begins, so no cycle ever mixes two commands.

The counter advances on a prescaled tick: every clock, every fourth clock or every eighth clock. A qualified rising edge on the external synchronisation input restarts the cycle, so several controllers can share one switching frequency. Protection has three layers:
- A current-limit input cuts the running pulses until the next cycle begins.
- An over-current shutdown input latches every output into its own shutdown level.
- An enable input with selectable polarity parks each output at its own disable level.

While the converter is running, software can force chosen outputs to a fixed level and leave the others modulating.

Top module: `mpwm_ctrl`

## Requirements
- R1: While reset is held, and until the first clock edge after its release, `ph_out` is all zeros and `cycle_start` is 0, whatever the stop levels are.
- R2: The count runs from 0 to `period` and then returns to 0. Each count value lasts 1, 4 or 8 clocks for `presc_sel` equal to 00, 01 or 1x (10 and 11 both give 8). `cycle_start` is high for one clock, in the clock where the count is 0.
- R3: Output i is high in the clock after a count c for which `rise_bus[i*9 +: 9]` <= c < rise + u, where u is the latched duty. With u = 0 the output never goes high. When rise + u exceeds `period`, the output stays high to the end of the cycle.
- R4: u is `loop_duty` when `duty_src` = 0 and `cpu_duty` when `duty_src` = 1. It is sampled only at the start of a cycle, so a change during a cycle has no effect on that cycle.
- R5: The supply runs when `enable_in` equals `enable_pol`. Otherwise `ph_out` equals `dis_level` from the next clock onward.
- R6: A single clock of `ocp_in` puts `ocp_level` on `ph_out` from the next clock onward. This holds until the supply is disabled, and it takes precedence over the disable level. Once enabled again, the supply modulates normally.
- R7: While the supply runs, `climit_in` drives every output that is not bypassed low, from the next clock until the first clock after the next cycle start.
- R8: While the supply runs, an output with `byp_en[i]` = 1 shows `byp_val[i]`, and the other outputs keep their modulated pattern.
- R9: The synchronisation input is sampled on count ticks. A high sample that follows at least 3 consecutive low samples restarts the count at 0 and raises `cycle_start` in the next clock. A high sample that follows fewer low samples is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_sel | input | 2 | Count tick rate: 00 every clock, 01 every 4, 1x every 8 |
| period | input | 9 | Last count value of a cycle |
| loop_duty | input | 9 | Duty command from the loop filter |
| cpu_duty | input | 9 | Duty command from the processor |
| duty_src | input | 1 | 0 selects loop_duty, 1 selects cpu_duty |
| rise_bus | input | 54 | Rising count of each output, 9 bits per output, output 0 lowest |
| enable_in | input | 1 | Supply on/off request |
| enable_pol | input | 1 | Level of enable_in that means on |
| sync_in | input | 1 | External cycle synchronisation |
| climit_in | input | 1 | Current-limit terminate request |
| ocp_in | input | 1 | Over-current shutdown request |
| dis_level | input | 6 | Per-output level while disabled |
| ocp_level | input | 6 | Per-output level after shutdown |
| byp_en | input | 6 | Per-output software force enable |
| byp_val | input | 6 | Per-output forced level |
| ph_out | output | 6 | Gate-control outputs |
| cycle_start | output | 1 | High in the clock where the count is 0 |

## Verification
The hardest condition to reach from the ports is the synchronisation boundary. An edge after exactly two low ticks must be rejected, and an edge after three must be accepted, both well before the counter wraps on its own. The stimulus first lets a long low stretch restart the cycle. It then places a two-sample low gap and a three-sample low gap a few counts into a long period, and watches `cycle_start` clock by clock. Current-limit termination is also placed at a known count inside a measured cycle, so that the cut and the resume at the next cycle can both be compared against the expected pattern.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  // Low samples needed before a synchronisation edge counts
  localparam int unsigned SYNC_LOW_MIN = 3;

  typedef enum logic [1:0] {
    PRE_FULL    = 2'b00,
    PRE_QUARTER = 2'b01,
    PRE_EIGHTH  = 2'b10,
    PRE_EIGHTH2 = 2'b11
  } presc_e;

  // Output window: high while rise <= c < rise + u
  function automatic logic edge_on(int unsigned c, int unsigned rise, int unsigned u);
    return (c >= rise) && (c < rise + u);
  endfunction

endpackage

// File: rtl/mpwm_prescaler.sv
module mpwm_prescaler import mpwm_pkg::*; #(
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PRE_W = $clog2(DIV_SLOW);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case (presc_e'(sel))
      PRE_FULL:    lim = '0;
      PRE_QUARTER: lim = PRE_W'(DIV_MID - 1);
      default:     lim = PRE_W'(DIV_SLOW - 1);
    endcase
  end

  // >= keeps the divider safe when the rate is lowered mid-count
  assign tick = (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/mpwm_timebase.sv
module mpwm_timebase import mpwm_pkg::*; #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cyc_evt,
  output logic             sync_hit
);
  localparam int LR_W = $clog2(SYNC_LOW_MIN + 1);

  logic [LR_W-1:0] low_run;
  logic            low_ok;

  assign low_ok   = (low_run >= LR_W'(SYNC_LOW_MIN));
  assign sync_hit = tick & sync_in & low_ok;
  assign cyc_evt  = tick & (sync_hit | (cnt_q >= period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (tick) begin
      if (sync_in)     low_run <= '0;
      else if (!low_ok) low_run <= low_run + LR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cyc_evt) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan import mpwm_pkg::*; #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] rise,
  input  logic             ocp_act,
  input  logic             en_ok,
  input  logic             term,
  input  logic             byp_on,
  input  logic             byp_lvl,
  input  logic             dis_lvl,
  input  logic             ocp_lvl,
  output logic             ph
);
  logic mod_on;

  assign mod_on = edge_on(32'(cnt), 32'(rise), 32'(duty));

  // Precedence: shutdown, disable, software force, current limit, modulation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= 1'b0;
    else if (ocp_act) ph <= ocp_lvl;
    else if (!en_ok)  ph <= dis_lvl;
    else if (byp_on)  ph <= byp_lvl;
    else if (term)    ph <= 1'b0;
    else              ph <= mod_on;
  end
endmodule

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl import mpwm_pkg::*; #(
  parameter int NUM_OUT  = 6,
  parameter int CNT_W    = 9,
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               presc_sel,
  input  logic [CNT_W-1:0]         period,
  input  logic [CNT_W-1:0]         loop_duty,
  input  logic [CNT_W-1:0]         cpu_duty,
  input  logic                     duty_src,
  input  logic [NUM_OUT*CNT_W-1:0] rise_bus,
  input  logic                     enable_in,
  input  logic                     enable_pol,
  input  logic                     sync_in,
  input  logic                     climit_in,
  input  logic                     ocp_in,
  input  logic [NUM_OUT-1:0]       dis_level,
  input  logic [NUM_OUT-1:0]       ocp_level,
  input  logic [NUM_OUT-1:0]       byp_en,
  input  logic [NUM_OUT-1:0]       byp_val,
  output logic [NUM_OUT-1:0]       ph_out,
  output logic                     cycle_start
);
  logic             tick;
  logic             cyc_evt;
  logic             sync_hit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] u_sel;
  logic [CNT_W-1:0] u_lat;
  logic             lim_hold;
  logic             ocp_hold;
  logic             en_ok;
  logic             ocp_act;
  logic             term;
  logic             run_ok;

  mpwm_prescaler #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(presc_sel), .tick(tick)
  );

  mpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_in(sync_in), .period(period),
    .cnt_q(cnt_q), .cyc_evt(cyc_evt), .sync_hit(sync_hit)
  );

  assign u_sel   = duty_src ? cpu_duty : loop_duty;
  assign en_ok   = (enable_in == enable_pol);
  assign ocp_act = ocp_in | ocp_hold;
  assign term    = climit_in | lim_hold;
  assign run_ok  = en_ok & ~ocp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_lat       <= '0;
      cycle_start <= 1'b0;
      lim_hold    <= 1'b0;
      ocp_hold    <= 1'b0;
    end else begin
      cycle_start <= cyc_evt;
      if (cyc_evt) u_lat <= u_sel;
      if (climit_in)    lim_hold <= 1'b1;
      else if (cyc_evt) lim_hold <= 1'b0;
      if (ocp_in)      ocp_hold <= 1'b1;
      else if (!en_ok) ocp_hold <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    mpwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .duty(u_lat),
      .rise(rise_bus[g*CNT_W +: CNT_W]),
      .ocp_act(ocp_act), .en_ok(en_ok), .term(term),
      .byp_on(byp_en[g]), .byp_lvl(byp_val[g]),
      .dis_lvl(dis_level[g]), .ocp_lvl(ocp_level[g]),
      .ph(ph_out[g])
    );
  end
endmodule

// File: rtl/mpwm_ctrl_chk.sv
module mpwm_ctrl_chk #(
  parameter int NUM_OUT = 6,
  parameter int CNT_W   = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ocp_in,
  input logic               ocp_hold,
  input logic               climit_in,
  input logic               run_ok,
  input logic               enable_in,
  input logic               enable_pol,
  input logic [NUM_OUT-1:0] dis_level,
  input logic [NUM_OUT-1:0] ocp_level,
  input logic [NUM_OUT-1:0] byp_en,
  input logic [NUM_OUT-1:0] ph_out,
  input logic               cycle_start,
  input logic               cyc_evt,
  input logic               sync_hit,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [CNT_W-1:0]   u_lat
);
  // R6
  ocp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_in |=> (ph_out == $past(ocp_level)));

  // R5
  dis_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ocp_in && !ocp_hold && (enable_in != enable_pol)) |=> (ph_out == $past(dis_level)));

  // R7
  climit_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (climit_in && run_ok) |=> ((ph_out & ~$past(byp_en)) == '0));

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (cnt_q == '0));

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_evt |=> $stable(u_lat));

  // R9
  sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> cycle_start);
endmodule

bind mpwm_ctrl mpwm_ctrl_chk #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ocp_in(ocp_in), .ocp_hold(ocp_hold),
  .climit_in(climit_in), .run_ok(run_ok), .enable_in(enable_in),
  .enable_pol(enable_pol), .dis_level(dis_level), .ocp_level(ocp_level),
  .byp_en(byp_en), .ph_out(ph_out), .cycle_start(cycle_start),
  .cyc_evt(cyc_evt), .sync_hit(sync_hit), .cnt_q(cnt_q), .u_lat(u_lat)
);

// File: tb/mpwm_ctrl_test.sv
`timescale 1ns/1ps
module mpwm_ctrl_test;
  localparam int NO = 6;
  localparam int CW = 9;
  localparam int RISE [NO] = '{0, 1, 2, 3, 5, 7};

  typedef struct packed {
    logic [1:0] ps;
    logic [8:0] per;
    logic [8:0] lu;
    logic [8:0] cu;
    logic       src;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 9'd9,  9'd5,  9'd2, 1'b0},
    '{2'b00, 9'd9,  9'd2,  9'd7, 1'b1},
    '{2'b01, 9'd7,  9'd3,  9'd0, 1'b0},
    '{2'b10, 9'd5,  9'd4,  9'd1, 1'b0},
    '{2'b11, 9'd5,  9'd1,  9'd3, 1'b1},
    '{2'b00, 9'd12, 9'd20, 9'd0, 1'b0},
    '{2'b00, 9'd9,  9'd0,  9'd9, 1'b0}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0]     presc_sel = 0;
  logic [CW-1:0]  period = 9;
  logic [CW-1:0]  loop_duty = 0;
  logic [CW-1:0]  cpu_duty = 0;
  logic           duty_src = 0;
  logic [NO*CW-1:0] rise_bus;
  logic enable_in = 1, enable_pol = 1, sync_in = 0, climit_in = 0, ocp_in = 0;
  logic [NO-1:0] dis_level = 6'b101001;
  logic [NO-1:0] ocp_level = 6'b010110;
  logic [NO-1:0] byp_en = 0, byp_val = 0;
  logic [NO-1:0] ph_out;
  logic cycle_start;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < NO; i++) begin : g_rise
    assign rise_bus[i*CW +: CW] = CW'(RISE[i]);
  end

  mpwm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .period(period),
    .loop_duty(loop_duty), .cpu_duty(cpu_duty), .duty_src(duty_src),
    .rise_bus(rise_bus), .enable_in(enable_in), .enable_pol(enable_pol),
    .sync_in(sync_in), .climit_in(climit_in), .ocp_in(ocp_in),
    .dis_level(dis_level), .ocp_level(ocp_level), .byp_en(byp_en),
    .byp_val(byp_val), .ph_out(ph_out), .cycle_start(cycle_start)
  );

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected outputs for count c, written from the window rule of R3 and R8
  function automatic logic [NO-1:0] expect_vec(int u, int c, logic [NO-1:0] bm,
                                              logic [NO-1:0] bv, logic cut);
    logic [NO-1:0] r;
    for (int i = 0; i < NO; i++) begin
      int diff = c - RISE[i];
      r[i] = (diff >= 0) && (diff < u) && !cut;
      if (bm[i]) r[i] = bv[i];
    end
    return r;
  endfunction

  task automatic wait_start();
    @(negedge clk);
    while (!cycle_start) @(negedge clk);
  endtask

  task automatic check_pattern(input string req, input int u, input int per, input int d,
                               input logic [NO-1:0] bm, input logic [NO-1:0] bv,
                               input int cut_k, input int chg_k, input logic [CW-1:0] chg_v);
    logic bad = 0;
    logic [NO-1:0] got_b = 0, exp_b = 0, e;
    wait_start();
    for (int k = 1; k <= (per + 1) * d; k++) begin
      @(negedge clk);
      e = expect_vec(u, (k - 1) / d, bm, bv, (cut_k >= 0) && (k > cut_k));
      if (ph_out !== e && !bad) begin
        bad = 1; got_b = ph_out; exp_b = e;
      end
      if (k == cut_k)     climit_in = 1;
      if (k == cut_k + 1) climit_in = 0;
      if (k == chg_k)     cpu_duty = chg_v;
    end
    check(req, !bad, 32'(got_b), 32'(exp_b));
  endtask

  task automatic hold_check(input string req, input int n, input logic [NO-1:0] exp);
    logic bad = 0;
    logic [NO-1:0] got_b = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (ph_out !== exp && !bad) begin bad = 1; got_b = ph_out; end
    end
    check(req, !bad, 32'(got_b), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: outputs held low during reset despite nonzero stop levels
    repeat (3) @(negedge clk);
    check("R1 reset", (ph_out == 0) && (cycle_start == 0), {25'd0, cycle_start, ph_out}, 0);
    rst_n = 1;

    // R2 R3 R4: table walk over prescale, period, source and duty
    for (int v = 0; v < NV; v++) begin
      int d;
      @(negedge clk);
      presc_sel = VEC[v].ps; period = VEC[v].per;
      loop_duty = VEC[v].lu; cpu_duty = VEC[v].cu; duty_src = VEC[v].src;
      d = (VEC[v].ps == 2'b00) ? 1 : (VEC[v].ps == 2'b01) ? 4 : 8;
      wait_start();
      check_pattern("R2/R3/R4 vector", VEC[v].src ? int'(VEC[v].cu) : int'(VEC[v].lu),
                    int'(VEC[v].per), d, 0, 0, -1, -1, 0);
    end

    // R4: mid-cycle command change is not seen until the next cycle
    @(negedge clk);
    presc_sel = 0; period = 9; duty_src = 1; cpu_duty = 3;
    wait_start();
    check_pattern("R4 hold in cycle", 3, 9, 1, 0, 0, -1, 2, 9'd8);
    check_pattern("R4 new cycle", 8, 9, 1, 0, 0, -1, -1, 0);

    // R8: force out0 high and out1 low, others keep modulating
    @(negedge clk);
    byp_en = 6'b000011; byp_val = 6'b000001;
    wait_start();
    check_pattern("R8 bypass", 8, 9, 1, 6'b000011, 6'b000001, -1, -1, 0);
    @(negedge clk);
    byp_en = 0; byp_val = 0;
    wait_start();

    // R7: current limit at k=4 cuts the rest of the cycle, next cycle resumes
    check_pattern("R7 cut", 8, 9, 1, 0, 0, 4, -1, 0);
    check_pattern("R7 resume", 8, 9, 1, 0, 0, -1, -1, 0);

    // R6: one-clock shutdown pulse latches the shutdown levels
    @(negedge clk);
    ocp_in = 1;
    @(negedge clk);
    ocp_in = 0;
    check("R6 ocp next clock", ph_out == ocp_level, 32'(ph_out), 32'(ocp_level));
    hold_check("R6 ocp held while enabled", 30, ocp_level);
    enable_in = 0;
    repeat (2) @(negedge clk);
    check("R6 disable clears ocp", ph_out == dis_level, 32'(ph_out), 32'(dis_level));
    enable_in = 1;
    wait_start();
    check_pattern("R6 recovery", 8, 9, 1, 0, 0, -1, -1, 0);

    // R5: active-low polarity; enable_in=1 now means off
    @(negedge clk);
    enable_pol = 0;
    @(negedge clk);
    check("R5 pol low disabled", ph_out == dis_level, 32'(ph_out), 32'(dis_level));
    hold_check("R5 disabled held", 20, dis_level);
    enable_in = 0;
    wait_start();
    check_pattern("R5 pol low running", 8, 9, 1, 0, 0, -1, -1, 0);
    @(negedge clk);
    enable_pol = 1; enable_in = 1;

    // R9: synchronisation edge qualification
    period = 40; duty_src = 0; loop_duty = 5;
    wait_start();
    repeat (5) @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    check("R9 accept after long low", cycle_start == 1'b1, 32'(cycle_start), 1);
    repeat (2) @(negedge clk);
    sync_in = 0;
    repeat (2) @(negedge clk);
    sync_in = 1;
    begin
      logic seen = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (cycle_start) seen = 1;
      end
      check("R9 reject after 2 low", seen == 1'b0, 32'(seen), 0);
    end
    sync_in = 0;
    repeat (3) @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    check("R9 accept after 3 low", cycle_start == 1'b1, 32'(cycle_start), 1);
    sync_in = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule